// File: doc/BRIEF.md
# Selectable-Width Endian Bus Adapter

This block joins a 36-bit internal memory word to an external data port whose width is picked at run time: the full 36 bits, an 18-bit half-word port or a 9-bit byte port. In the two narrow settings, one internal word moves as several lanes on consecutive transfer cycles. On a read, the adapter slices the word presented by the memory side and places one lane per transfer on the low port bits. On a write, it gathers lanes from the port into a shadow word and hands the completed word to the memory side with a one-cycle strobe.

A level input picks the lane order. With it low, the least significant lane goes first. With it high, the most significant lane goes first. An internal lane counter steps on every transfer cycle and wraps after the final lane. A change to any configuration input (width, order or direction) restarts the counter at the first lane. Address generation, arbitration and the storage array belong to the surrounding logic.

Top module: `endian_width_adapter`

## Requirements
- R1: With `busMatch` = 0, every transfer is a complete access. A read drives all 36 bits of `portDout` with `memRdData`, sets all 36 bits of `portOe` and raises `memRdNext`. A write of `portDin` is strobed on the next cycle.
- R2: With `busMatch` = 1 and `sizeSel` = 0 (half mode), an access takes two transfers. Each transfer moves 18 bits on port bits 17..0. On a read transfer, `portOe` is 1 on bits 17..0 and 0 on bits 35..18.
- R3: With `busMatch` = 1 and `sizeSel` = 1 (byte mode), an access takes four transfers. Each transfer moves 9 bits on port bits 8..0. On a read transfer, `portOe` is 1 on bits 8..0 and 0 on bits 35..9.
- R4: With `bigEndian` = 0, transfer k of an access carries word lane k, where lane p occupies bits [p*W+W-1 : p*W] for a lane width W.
- R5: With `bigEndian` = 1, transfer k carries word lane N-1-k, where N is the number of lanes, so the most significant lane goes first.
- R6: On write transfers, each lane is stored into its own position of the word. One cycle after the final lane, `memWrStrobe` is high for exactly one cycle and `memWrData` holds the assembled word. At no other time is `memWrStrobe` high.
- R7: On read transfers, `portDout` carries the selected lane of `memRdData` as it stands in that cycle. `memRdNext` is high in the cycle of the final lane's read transfer and low in every other cycle.
- R8: Cycles with `portValid` = 0 do not advance the lane counter. After the final lane, the counter returns to the first lane.
- R9: If `busMatch`, `sizeSel`, `bigEndian` or `portWrite` differs from its value in the previous cycle, the current cycle counts as transfer 0 of a new access. A partly collected write is dropped and never strobed.
- R10: After reset, the first transfer is transfer 0, `memWrStrobe` is 0 and `portOe` is all 0 until a read transfer occurs.
- R11: `portOe` and `portDout` are all 0 in any cycle where `portValid` = 0 or `portWrite` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busMatch | input | 1 | 0: full-width port, 1: narrow port |
| sizeSel | input | 1 | Narrow width select, 0: 18-bit, 1: 9-bit |
| bigEndian | input | 1 | Lane order, 1: most significant lane first |
| portValid | input | 1 | A port transfer happens this cycle |
| portWrite | input | 1 | Transfer direction, 1: port to memory |
| portDin | input | 36 | Port write data; the lane uses the low bits |
| portDout | output | 36 | Port read data; the lane uses the low bits |
| portOe | output | 36 | Per-bit output enable for the port |
| memRdData | input | 36 | Word being read from the memory side |
| memRdNext | output | 1 | Final lane of the read word taken this cycle |
| memWrData | output | 36 | Assembled word for the memory side |
| memWrStrobe | output | 1 | One-cycle commit of `memWrData` |

## Verification
The assertions assume that every input holds a known 0 or 1 value from the first cycle after reset. They also assume that `memRdData` needs no particular relation to the transfer sequence, because the properties only tie the enables and strobes to the transfer and direction inputs. The stimulus drives every input on each falling edge with defined values. It changes the configuration only between whole cycles, both at access boundaries and in the middle of an access, so every restart case is a legal input pattern.

// File: rtl/ewa_pkg.sv
package ewa_pkg;

  typedef enum logic [1:0] {
    WIDTH_FULL = 2'd0,
    WIDTH_HALF = 2'd1,
    WIDTH_QTR  = 2'd2
  } widthMode_e;

  typedef struct packed {
    widthMode_e mode;
    logic [1:0] lanePos;
    logic       laneFire;
    logic       lastLane;
    logic       isWrite;
  } laneCtrl_t;

  typedef struct packed {
    widthMode_e mode;
    logic       bigEndian;
    logic       isWrite;
  } portCfg_t;

  function automatic widthMode_e decodeWidth(input logic busMatch, input logic sizeSel);
    if (!busMatch) return WIDTH_FULL;
    else if (sizeSel) return WIDTH_QTR;
    else return WIDTH_HALF;
  endfunction

endpackage

// File: rtl/ewa_lane_ctrl.sv
module ewa_lane_ctrl
  import ewa_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      busMatch,
  input  logic      sizeSel,
  input  logic      bigEndian,
  input  logic      portValid,
  input  logic      portWrite,
  output laneCtrl_t ctrl
);

  portCfg_t   curCfg;
  portCfg_t   prevCfg;
  logic [1:0] idxQ;
  logic [1:0] effIdx;
  logic [1:0] lastIdx;
  logic       restart;
  logic       isLast;

  always_comb begin
    curCfg.mode      = decodeWidth(busMatch, sizeSel);
    curCfg.bigEndian = bigEndian;
    curCfg.isWrite   = portWrite;
    restart = (curCfg != prevCfg);
    effIdx  = restart ? 2'd0 : idxQ;
    unique case (curCfg.mode)
      WIDTH_HALF: lastIdx = 2'd1;
      WIDTH_QTR:  lastIdx = 2'd3;
      default:    lastIdx = 2'd0;
    endcase
    isLast = (effIdx == lastIdx);
    ctrl.mode     = curCfg.mode;
    ctrl.lanePos  = bigEndian ? (lastIdx - effIdx) : effIdx;
    ctrl.laneFire = portValid;
    ctrl.lastLane = isLast;
    ctrl.isWrite  = portWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ    <= 2'd0;
      prevCfg <= '{mode: WIDTH_FULL, bigEndian: 1'b0, isWrite: 1'b0};
    end else begin
      prevCfg <= curCfg;
      if (portValid) idxQ <= isLast ? 2'd0 : effIdx + 2'd1;
      else           idxQ <= effIdx;
    end
  end

endmodule

// File: rtl/ewa_datapath.sv
module ewa_datapath
  import ewa_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneCtrl_t         ctrl,
  input  logic [WORD_W-1:0] portDin,
  input  logic [WORD_W-1:0] memRdData,
  output logic [WORD_W-1:0] portDout,
  output logic [WORD_W-1:0] portOe,
  output logic              memRdNext,
  output logic [WORD_W-1:0] memWrData,
  output logic              memWrStrobe
);

  localparam int HALF_W = WORD_W / 2;
  localparam int QTR_W  = WORD_W / 4;
  localparam logic [WORD_W-1:0] HALF_MASK = {{(WORD_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [WORD_W-1:0] QTR_MASK  = {{(WORD_W-QTR_W){1'b0}}, {QTR_W{1'b1}}};

  logic [WORD_W-1:0] laneMask;
  logic [WORD_W-1:0] wordBuf;
  logic [WORD_W-1:0] merged;
  int                shift;
  logic              rdFire;
  logic              wrFire;

  always_comb begin
    unique case (ctrl.mode)
      WIDTH_HALF: begin laneMask = HALF_MASK; shift = int'(ctrl.lanePos) * HALF_W; end
      WIDTH_QTR:  begin laneMask = QTR_MASK;  shift = int'(ctrl.lanePos) * QTR_W;  end
      default:    begin laneMask = '1;        shift = 0;                          end
    endcase
    rdFire    = ctrl.laneFire && !ctrl.isWrite;
    wrFire    = ctrl.laneFire && ctrl.isWrite;
    merged    = (wordBuf & ~(laneMask << shift)) | ((portDin & laneMask) << shift);
    portOe    = rdFire ? laneMask : '0;
    portDout  = rdFire ? ((memRdData >> shift) & laneMask) : '0;
    memRdNext = rdFire && ctrl.lastLane;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordBuf     <= '0;
      memWrData   <= '0;
      memWrStrobe <= 1'b0;
    end else begin
      memWrStrobe <= wrFire && ctrl.lastLane;
      if (wrFire) begin
        wordBuf <= merged;
        if (ctrl.lastLane) memWrData <= merged;
      end
    end
  end

endmodule

// File: rtl/endian_width_adapter.sv
module endian_width_adapter
  import ewa_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busMatch,
  input  logic              sizeSel,
  input  logic              bigEndian,
  input  logic              portValid,
  input  logic              portWrite,
  input  logic [WORD_W-1:0] portDin,
  output logic [WORD_W-1:0] portDout,
  output logic [WORD_W-1:0] portOe,
  input  logic [WORD_W-1:0] memRdData,
  output logic              memRdNext,
  output logic [WORD_W-1:0] memWrData,
  output logic              memWrStrobe
);

  laneCtrl_t laneCtrl;

  ewa_lane_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .busMatch  (busMatch),
    .sizeSel   (sizeSel),
    .bigEndian (bigEndian),
    .portValid (portValid),
    .portWrite (portWrite),
    .ctrl      (laneCtrl)
  );

  ewa_datapath #(.WORD_W(WORD_W)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (laneCtrl),
    .portDin     (portDin),
    .memRdData   (memRdData),
    .portDout    (portDout),
    .portOe      (portOe),
    .memRdNext   (memRdNext),
    .memWrData   (memWrData),
    .memWrStrobe (memWrStrobe)
  );

endmodule

// File: rtl/ewa_checker.sv
module ewa_checker #(
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              busMatch,
  input logic              sizeSel,
  input logic              portValid,
  input logic              portWrite,
  input logic [WORD_W-1:0] portOe,
  input logic              memRdNext,
  input logic              memWrStrobe
);

  localparam int HALF_W = WORD_W / 2;
  localparam int QTR_W  = WORD_W / 4;

  // R1: a full-width write transfer is committed on the next cycle
  a_r1_full_write_commits: assert property (@(posedge clk) disable iff (!rstN)
    (portValid && portWrite && !busMatch) |=> memWrStrobe);

  // R1: a full-width read transfer completes the word at once
  a_r1_full_read_next: assert property (@(posedge clk) disable iff (!rstN)
    (portValid && !portWrite && !busMatch) |-> (memRdNext && portOe == {WORD_W{1'b1}}));

  // R2: half mode enables only the low half of the port
  a_r2_half_oe: assert property (@(posedge clk) disable iff (!rstN)
    (portValid && !portWrite && busMatch && !sizeSel) |->
      (portOe == {{(WORD_W-HALF_W){1'b0}}, {HALF_W{1'b1}}}));

  // R3: byte mode enables only the low byte lane
  a_r3_byte_oe: assert property (@(posedge clk) disable iff (!rstN)
    (portValid && !portWrite && busMatch && sizeSel) |->
      (portOe == {{(WORD_W-QTR_W){1'b0}}, {QTR_W{1'b1}}}));

  // R6: a commit strobe only follows a write transfer
  a_r6_strobe_after_write: assert property (@(posedge clk) disable iff (!rstN)
    memWrStrobe |-> $past(portValid && portWrite));

  // R7: read-complete only on a read transfer
  a_r7_rdnext_on_read: assert property (@(posedge clk) disable iff (!rstN)
    memRdNext |-> (portValid && !portWrite));

  // R11: the port is not driven outside read transfers
  a_r11_oe_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!portValid || portWrite) |-> (portOe == '0));

endmodule

bind endian_width_adapter ewa_checker #(.WORD_W(WORD_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .busMatch    (busMatch),
  .sizeSel     (sizeSel),
  .portValid   (portValid),
  .portWrite   (portWrite),
  .portOe      (portOe),
  .memRdNext   (memRdNext),
  .memWrStrobe (memWrStrobe)
);

// File: tb/tb_endian_width_adapter.sv
`timescale 1ns/1ps
module tb_endian_width_adapter;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busMatch, sizeSel, bigEndian, portValid, portWrite;
  logic [35:0] portDin, portDout, portOe, memRdData, memWrData;
  logic        memRdNext, memWrStrobe;

  int checks = 0;
  int failures = 0;

  // reference model state
  int          mIdx, mPrevMode, mPrevBe, mPrevWr;
  logic [35:0] mBuf, mExpWd;
  bit          mExpStb;

  endian_width_adapter dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [35:0] ones(input int w);
    logic [35:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = 1'b1;
    return r;
  endfunction

  // Drive one cycle at the falling edge, compare just after, then advance the model.
  task automatic cyc(input bit bm, input bit sz, input bit be, input bit v, input bit wr,
                     input logic [35:0] din, input logic [35:0] rd);
    int m, n, w, k, pos, sh;
    bit restart, last;
    logic [35:0] msk, expDout, expOe, merged;
    string mt;
    @(negedge clk);
    busMatch = bm; sizeSel = sz; bigEndian = be; portValid = v; portWrite = wr;
    portDin = din; memRdData = rd;
    #1;
    m = !bm ? 0 : (sz ? 2 : 1);
    n = 1 << m;
    w = 36 / n;
    restart = (m != mPrevMode) || (be != mPrevBe) || (wr != mPrevWr);
    k = restart ? 0 : mIdx;
    pos = be ? (n - 1 - k) : k;
    last = (k == n - 1);
    sh = pos * w;
    msk = ones(w);
    mt = (m == 0) ? "R1" : ((m == 1) ? "R2" : "R3");
    if (v && !wr) begin
      expOe = msk;
      expDout = (rd >> sh) & msk;
      check(portOe === expOe, mt, portOe, expOe);
      check(portDout === expDout, restart ? "R9" : (be ? "R5" : "R4"), portDout, expDout);
      check(memRdNext === last, "R7", {35'd0, memRdNext}, {35'd0, last});
    end else begin
      check(portOe === '0 && portDout === '0, "R11", portOe | portDout, '0);
      check(memRdNext === 1'b0, "R7", {35'd0, memRdNext}, '0);
    end
    check(memWrStrobe === mExpStb, "R6", {35'd0, memWrStrobe}, {35'd0, mExpStb});
    if (mExpStb) check(memWrData === mExpWd, "R6", memWrData, mExpWd);
    merged = (mBuf & ~(msk << sh)) | ((din & msk) << sh);
    mExpStb = v && wr && last;
    if (v && wr) begin
      mBuf = merged;
      if (last) mExpWd = merged;
    end
    mIdx = v ? (last ? 0 : k + 1) : k;
    mPrevMode = m; mPrevBe = be; mPrevWr = wr;
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [35:0] word;
    rstN = 1'b0; busMatch = 0; sizeSel = 0; bigEndian = 0; portValid = 0; portWrite = 0;
    portDin = '0; memRdData = '0;
    mIdx = 0; mPrevMode = 0; mPrevBe = 0; mPrevWr = 0; mBuf = '0; mExpWd = '0; mExpStb = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10: reset state
    check(portOe === '0, "R10", portOe, '0);
    check(memWrStrobe === 1'b0, "R10", {35'd0, memWrStrobe}, '0);

    // R10: first transfer after reset is lane 0 (half, little endian)
    word = 36'h9_A5C3_1E7F;
    cyc(1, 0, 0, 1, 0, '0, word);
    check(portDout === {18'd0, word[17:0]}, "R10", portDout, {18'd0, word[17:0]});

    // R8: idle gaps do not advance the counter
    cyc(1, 0, 0, 0, 0, '0, word);
    cyc(1, 0, 0, 0, 0, '0, word);
    cyc(1, 0, 0, 1, 0, '0, word);
    check(portDout === {18'd0, word[35:18]} && memRdNext, "R8", portDout, {18'd0, word[35:18]});
    cyc(1, 0, 0, 1, 0, '0, word);
    check(portDout === {18'd0, word[17:0]}, "R8", portDout, {18'd0, word[17:0]});
    cyc(1, 0, 0, 1, 0, '0, word);

    // R5: byte mode big endian read, most significant byte first
    cyc(1, 1, 1, 1, 0, '0, word);
    check(portDout === {27'd0, word[35:27]}, "R5", portDout, {27'd0, word[35:27]});
    cyc(1, 1, 1, 1, 0, '0, word);
    cyc(1, 1, 1, 1, 0, '0, word);
    cyc(1, 1, 1, 1, 0, '0, word);
    check(portDout === {27'd0, word[8:0]} && memRdNext, "R5", portDout, {27'd0, word[8:0]});

    // R4/R6: byte mode little endian write assembles lanes
    cyc(1, 1, 0, 1, 1, 36'h0_0000_0011, '0);
    cyc(1, 1, 0, 1, 1, 36'h0_0000_0122, '0);
    cyc(1, 1, 0, 1, 1, 36'h0_0000_0033, '0);
    cyc(1, 1, 0, 1, 1, 36'h0_0000_01C4, '0);
    cyc(1, 1, 0, 0, 1, '0, '0);
    word = {9'h1C4, 9'h033, 9'h122, 9'h011};
    check(memWrStrobe && memWrData === word, "R6", memWrData, word);

    // R9: partial write dropped by an endian change mid-access
    cyc(1, 1, 0, 1, 1, 36'h0_0000_00AA, '0);
    cyc(1, 1, 0, 1, 1, 36'h0_0000_00BB, '0);
    cyc(1, 1, 1, 1, 1, 36'h0_0000_0001, '0);
    cyc(1, 1, 1, 0, 1, '0, '0);
    check(memWrStrobe === 1'b0, "R9", {35'd0, memWrStrobe}, '0);

    // sweep of all width/order/direction settings
    for (int cfg = 0; cfg < 12; cfg++) begin
      for (int t = 0; t < 40; t++) begin
        cyc((cfg % 3) != 0, (cfg % 3) == 2, (cfg / 3) % 2, 1, cfg / 6,
            {$urandom, $urandom} , {$urandom, $urandom});
      end
    end

    // random phase with occasional mid-access configuration changes
    begin
      bit bm = 1, sz = 0, be = 0, wr = 0;
      for (int t = 0; t < 4000; t++) begin
        if ($urandom_range(0, 7) == 0) begin
          bm = $urandom_range(0, 1); sz = $urandom_range(0, 1);
          be = $urandom_range(0, 1); wr = $urandom_range(0, 1);
        end
        cyc(bm, sz, be, $urandom_range(0, 3) != 0, wr, {$urandom, $urandom}, {$urandom, $urandom});
      end
    end
    cyc(0, 0, 0, 0, 0, '0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule